// File: doc/BRIEF.md
# Weighted Round-Robin Queue Scheduler

This block chooses which command queue of a single output port is served next. Each queue has one row in a configuration table. The row holds an 8-bit round mask, a strict-priority flag, a flag that marks the last queue of the port, and a flag that marks the last strict-priority queue. A per-queue non-empty vector says which queues have work waiting. The block answers with a queue index on a valid/ready grant interface.

Scheduling runs in cycles of eight rounds. In round r, a round-robin queue may be picked only if bit r of its mask is set. A queue whose mask has k bits set therefore gets k slots in every eight rounds. For example, 0x01 gives weight 1, 0x55 gives weight 4 and 0xFF gives weight 8, and a mask of zero removes the queue from round-robin service. Strict-priority queues sit in a contiguous group at the head of the port and always win over round-robin queues.

The block also checks that the table is legal. When the table is illegal, it raises an error flag and grants nothing.

Back-pressure: once `grant_valid` rises, `grant_qid` stays frozen until `grant_ready` is seen high on a clock edge. The pointer moves only on that accepting edge. After an accept, `grant_valid` is low for at least one cycle while the next pick is formed.

Top module: `wrr_queue_sched`

## Requirements
- R1: With every listed queue non-empty and `grant_ready` held high, a round-robin queue is granted once in each round r whose mask bit r is set. Over eight rounds it is therefore served as many times as its mask has set bits.
- R2: A round-robin queue whose mask is 0x00 is never granted.
- R3: Whenever a listed strict-priority queue is non-empty, the next grant goes to the lowest-numbered non-empty strict-priority queue, ahead of every round-robin queue. Serving a strict-priority queue leaves the round and the pointer unchanged.
- R4: `cfg_error` is raised, and no grant is issued, when the strict-priority group does not start at queue 0 or is not contiguous, that is, when a strict-priority queue follows a queue that is not strict-priority.
- R5: `cfg_error` is also raised when the static-tail flags do not mark exactly the last strict-priority queue, or when a strict-priority queue has a mask other than 0xFF.
- R6: Queues are listed from index 0 up to and including the first queue whose tail flag is set; with no tail flag set, all queues are listed. Unlisted queues are never granted and are ignored by the legality check.
- R7: Within a round, round-robin queues are granted in ascending index order, starting from a pointer that moves to one past each accepted round-robin grant. When no eligible non-empty queue lies at or above the pointer, the round advances by one (wrapping from 7 to 0) and the pointer returns to 0.
- R8: When no queue is both eligible and non-empty, `grant_valid` stays low and the round keeps advancing, so a queue that is enabled in one round only is still granted within eight idle cycles.
- R9: While a grant is pending and not accepted, `grant_valid` stays high and `grant_qid` stays stable.
- R10: During and right after reset, `grant_valid` is low, the round is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mask | input | NQ*8 | Round mask of queue i in bits [8i+7:8i] |
| cfg_static | input | NQ | Strict-priority flag per queue |
| cfg_tail | input | NQ | Last-queue-of-port flag per queue |
| cfg_stail | input | NQ | Last-strict-priority-queue flag per queue |
| q_nonempty | input | NQ | Queue has work waiting |
| grant_valid | output | 1 | A grant is offered |
| grant_ready | input | 1 | Consumer accepts the offered grant |
| grant_qid | output | $clog2(NQ) | Index of the granted queue |
| cfg_error | output | 1 | Configuration table is illegal |

## Verification
The round-robin path is driven with a mix of weights that differ in every round: weight 8, weight 1, weight 0 and weight 4. Unlisted queues past the tail are left full at the same time. The exact grant order therefore separates a wrong mask bit, a wrong round step, a pointer that fails to rotate and a tail that is not honoured. A strict-priority setup is then drained one queue at a time with the accept held off. This separates strict priority from round-robin order and also exercises the hold rule. Four illegal tables, each breaking one rule, and one legal table with stray flags beyond the tail show whether the error check covers exactly the listed queues. A fully empty port followed by a single round-0-only queue shows that empty rounds are skipped rather than stalled in.

// File: rtl/wrr_sched_pkg.sv
package wrr_sched_pkg;
  localparam int ROUNDS = 8;
  localparam int RW     = $clog2(ROUNDS);
  localparam logic [ROUNDS-1:0] FULL_MASK = '1;
  typedef logic [RW-1:0] round_t;
endpackage

// File: rtl/wrr_cfg_check.sv
module wrr_cfg_check
  import wrr_sched_pkg::*;
#(
  parameter int NQ = 8
) (
  input  logic [NQ*ROUNDS-1:0] cfg_mask,
  input  logic [NQ-1:0]        cfg_static,
  input  logic [NQ-1:0]        cfg_tail,
  input  logic [NQ-1:0]        cfg_stail,
  output logic [NQ-1:0]        listed,
  output logic                 bad
);
  logic [NQ-1:0] next_static;
  logic [NQ-1:0] row_bad;

  // listed: up to and including the first tail flag
  assign listed[0] = 1'b1;
  genvar i;
  generate
    for (i = 1; i < NQ; i++) begin : g_list
      assign listed[i] = listed[i-1] & ~cfg_tail[i-1];
    end
    for (i = 0; i < NQ; i++) begin : g_row
      if (i == NQ - 1) begin : g_last
        assign next_static[i] = 1'b0;
      end else begin : g_mid
        assign next_static[i] = listed[i+1] & cfg_static[i+1];
      end
      logic gap;
      if (i == 0) begin : g_first
        assign gap = 1'b0;
      end else begin : g_other
        assign gap = cfg_static[i] & ~cfg_static[i-1];
      end
      logic stail_exp;
      assign stail_exp = cfg_static[i] & ~next_static[i];
      assign row_bad[i] = listed[i] &
                          (gap | (cfg_stail[i] != stail_exp) |
                           (cfg_static[i] & (cfg_mask[i*ROUNDS +: ROUNDS] != FULL_MASK)));
    end
  endgenerate

  assign bad = |row_bad;
endmodule

// File: rtl/wrr_first_from.sv
module wrr_first_from #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0] vec,
  input  logic [IW:0]  start,
  output logic         found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && vec[i] && (i >= int'(start))) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wrr_queue_sched.sv
module wrr_queue_sched
  import wrr_sched_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = $clog2(NQ)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NQ*ROUNDS-1:0] cfg_mask,
  input  logic [NQ-1:0]        cfg_static,
  input  logic [NQ-1:0]        cfg_tail,
  input  logic [NQ-1:0]        cfg_stail,
  input  logic [NQ-1:0]        q_nonempty,
  output logic                 grant_valid,
  input  logic                 grant_ready,
  output logic [QW-1:0]        grant_qid,
  output logic                 cfg_error
);
  logic [NQ-1:0] listed;
  logic [NQ-1:0] st_cand;
  logic [NQ-1:0] rr_cand;
  round_t        round_q;
  logic [QW:0]   ptr_q;
  logic          gv_q;
  logic [QW-1:0] gq_q;
  logic          gstat_q;
  logic          st_found, rr_found;
  logic [QW-1:0] st_idx, rr_idx;

  wrr_cfg_check #(.NQ(NQ)) u_check (
    .cfg_mask  (cfg_mask),
    .cfg_static(cfg_static),
    .cfg_tail  (cfg_tail),
    .cfg_stail (cfg_stail),
    .listed    (listed),
    .bad       (cfg_error)
  );

  genvar i;
  generate
    for (i = 0; i < NQ; i++) begin : g_cand
      assign st_cand[i] = listed[i] & cfg_static[i] & q_nonempty[i];
      assign rr_cand[i] = listed[i] & ~cfg_static[i] & q_nonempty[i] &
                          cfg_mask[i*ROUNDS + int'(round_q)];
    end
  endgenerate

  wrr_first_from #(.N(NQ)) u_st_pick (
    .vec(st_cand), .start('0), .found(st_found), .idx(st_idx)
  );

  wrr_first_from #(.N(NQ)) u_rr_pick (
    .vec(rr_cand), .start(ptr_q), .found(rr_found), .idx(rr_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      round_q <= '0;
      ptr_q   <= '0;
      gv_q    <= 1'b0;
      gq_q    <= '0;
      gstat_q <= 1'b0;
    end else if (cfg_error) begin
      gv_q <= 1'b0;
    end else if (gv_q) begin
      if (grant_ready) begin
        gv_q <= 1'b0;
        if (!gstat_q) ptr_q <= {1'b0, gq_q} + 1'b1;
      end
    end else if (st_found) begin
      gv_q    <= 1'b1;
      gq_q    <= st_idx;
      gstat_q <= 1'b1;
    end else if (rr_found) begin
      gv_q    <= 1'b1;
      gq_q    <= rr_idx;
      gstat_q <= 1'b0;
    end else begin
      round_q <= round_q + 1'b1;
      ptr_q   <= '0;
    end
  end

  assign grant_valid = gv_q;
  assign grant_qid   = gq_q;
endmodule

// File: rtl/wrr_sched_chk.sv
module wrr_sched_chk
  import wrr_sched_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = $clog2(NQ)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NQ*ROUNDS-1:0] cfg_mask,
  input logic [NQ-1:0]        cfg_static,
  input logic [NQ-1:0]        q_nonempty,
  input logic [NQ-1:0]        listed,
  input logic                 grant_valid,
  input logic                 grant_ready,
  input logic [QW-1:0]        grant_qid,
  input logic                 cfg_error
);
  // R4, R5: an illegal table withdraws any grant
  a_r4_error_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> !grant_valid);

  // R9: a grant that is not accepted is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready && !cfg_error) |=> (grant_valid && $stable(grant_qid)));

  // R6: only listed queues are granted
  a_r6_listed_only: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> listed[grant_qid]);

  // R2: a zero mask round-robin queue never wins
  a_r2_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !cfg_static[grant_qid]) |-> (cfg_mask[grant_qid*ROUNDS +: ROUNDS] != '0));

  // R3: pending strict-priority work wins the next grant
  a_r3_static_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant_valid) && $past(|(listed & cfg_static & q_nonempty))) |-> cfg_static[grant_qid]);
endmodule

bind wrr_queue_sched wrr_sched_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_static(cfg_static),
  .q_nonempty(q_nonempty), .listed(listed), .grant_valid(grant_valid),
  .grant_ready(grant_ready), .grant_qid(grant_qid), .cfg_error(cfg_error)
);

// File: tb/wrr_queue_sched_tb.sv
module wrr_queue_sched_tb;
  localparam int NQ = 8;
  localparam int QW = $clog2(NQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NQ*8-1:0] cfg_mask;
  logic [NQ-1:0] cfg_static, cfg_tail, cfg_stail, q_nonempty;
  logic grant_valid, grant_ready, cfg_error;
  logic [QW-1:0] grant_qid;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_q[$];
  bit sb_on = 1'b0;

  always #2 clk = ~clk;

  wrr_queue_sched #(.NQ(NQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_static(cfg_static),
    .cfg_tail(cfg_tail), .cfg_stail(cfg_stail), .q_nonempty(q_nonempty),
    .grant_valid(grant_valid), .grant_ready(grant_ready),
    .grant_qid(grant_qid), .cfg_error(cfg_error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // scoreboard monitor: every accepted grant is compared with the next expected queue
  always @(negedge clk) begin
    if (sb_on && grant_valid && grant_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1/R7 extra grant", int'(grant_qid), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(grant_qid) == e, "R1/R2/R6/R7 grant order", int'(grant_qid), e);
      end
    end
  end

  task automatic clear_cfg();
    cfg_mask = '0; cfg_static = '0; cfg_tail = '0; cfg_stail = '0;
    q_nonempty = '0; grant_ready = 1'b0;
  endtask

  task automatic set_mask(input int q, input logic [7:0] m);
    cfg_mask[q*8 +: 8] = m;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_grant(output bit got);
    got = 1'b0;
    for (int k = 0; k < 40 && !got; k++) begin
      @(negedge clk);
      got = grant_valid;
    end
  endtask

  task automatic accept_one();
    grant_ready = 1'b1;
    @(negedge clk);
    grant_ready = 1'b0;
  endtask

  task automatic expect_no_grant(input string req, input int cycles);
    bit seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (grant_valid) seen = 1'b1;
    end
    check(!seen, req, int'(seen), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin : main
    bit got;
    clear_cfg();
    // R10: reset state
    repeat (2) @(negedge clk);
    check(grant_valid == 1'b0, "R10 valid low in reset", int'(grant_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(grant_valid == 1'b0, "R10 valid low after reset", int'(grant_valid), 0);

    // Scenario A: weights 8,1,0,4 on queues 0..3, tail at 3; queues 4..7 full but unlisted (R1 R2 R6 R7)
    clear_cfg();
    set_mask(0, 8'hFF); set_mask(1, 8'h01); set_mask(2, 8'h00); set_mask(3, 8'h55);
    for (int q = 4; q < NQ; q++) set_mask(q, 8'hFF);
    cfg_tail = 8'b0000_1000;
    do_reset();
    check(cfg_error == 1'b0, "R4 legal table no error", int'(cfg_error), 0);
    for (int rep = 0; rep < 2; rep++) begin
      exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(3);
      for (int r = 1; r < 8; r++) begin
        exp_q.push_back(0);
        if (r % 2 == 0) exp_q.push_back(3);
      end
    end
    sb_on = 1'b1;
    q_nonempty = '1;
    grant_ready = 1'b1;
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(posedge clk);
    @(negedge clk);
    grant_ready = 1'b0;
    sb_on = 1'b0;
    check(exp_q.size() == 0, "R1 all expected grants seen", exp_q.size(), 0);

    // Scenario B: strict priority on 0,1 (stail 1), round-robin 2, tail at 2 (R3 R9)
    clear_cfg();
    set_mask(0, 8'hFF); set_mask(1, 8'hFF); set_mask(2, 8'hFF);
    cfg_static = 8'b0000_0011; cfg_stail = 8'b0000_0010; cfg_tail = 8'b0000_0100;
    q_nonempty = 8'b0000_0111;
    do_reset();
    check(cfg_error == 1'b0, "R5 legal static table", int'(cfg_error), 0);
    wait_grant(got);
    check(got && grant_qid == 0, "R3 static queue 0 first", int'(grant_qid), 0);
    q_nonempty = 8'b0000_0110;
    repeat (5) @(negedge clk);
    check(grant_valid && grant_qid == 0, "R9 grant held without accept", int'(grant_qid), 0);
    accept_one();
    wait_grant(got);
    check(got && grant_qid == 1, "R3 static queue 1 next", int'(grant_qid), 1);
    accept_one();
    wait_grant(got);
    check(got && grant_qid == 1, "R3 static repeats before round-robin", int'(grant_qid), 1);
    q_nonempty = 8'b0000_0100;
    accept_one();
    wait_grant(got);
    check(got && grant_qid == 2, "R3 round-robin after statics drain", int'(grant_qid), 2);
    q_nonempty = 8'b0000_0101;
    accept_one();
    wait_grant(got);
    check(got && grant_qid == 0, "R3 static preempts round-robin", int'(grant_qid), 0);
    accept_one();

    // Illegal tables (R4 R5)
    clear_cfg();
    set_mask(0, 8'h11); set_mask(1, 8'hFF);
    cfg_static = 8'b0000_0010; cfg_stail = 8'b0000_0010; cfg_tail = 8'b0000_0010;
    q_nonempty = 8'b0000_0011;
    do_reset();
    check(cfg_error == 1'b1, "R4 static not at start", int'(cfg_error), 1);
    expect_no_grant("R4 no grant on illegal table", 12);

    set_mask(0, 8'hFF); set_mask(1, 8'h11); set_mask(2, 8'hFF);
    cfg_static = 8'b0000_0101; cfg_stail = 8'b0000_0100; cfg_tail = 8'b0000_0100;
    #1;
    check(cfg_error == 1'b1, "R4 static run not contiguous", int'(cfg_error), 1);

    set_mask(1, 8'hFF);
    cfg_static = 8'b0000_0011; cfg_stail = 8'b0000_0001; cfg_tail = 8'b0000_0100;
    #1;
    check(cfg_error == 1'b1, "R5 static-tail on wrong queue", int'(cfg_error), 1);

    cfg_stail = 8'b0000_0010; set_mask(1, 8'h55);
    #1;
    check(cfg_error == 1'b1, "R5 static mask not full", int'(cfg_error), 1);

    // R6: stray flags beyond the tail do not count
    set_mask(1, 8'hFF);
    cfg_static = 8'b0010_0011; cfg_stail = 8'b1000_0010; set_mask(5, 8'h01);
    #1;
    check(cfg_error == 1'b0, "R6 unlisted rows not checked", int'(cfg_error), 0);

    // Empty port, then a round-0-only queue (R8)
    clear_cfg();
    set_mask(0, 8'hFF); set_mask(1, 8'h01);
    cfg_tail = 8'b0000_0010;
    do_reset();
    expect_no_grant("R8 valid low when all empty", 13);
    q_nonempty = 8'b0000_0010;
    wait_grant(got);
    check(got && grant_qid == 1, "R8 round advances past empty rounds", int'(grant_qid), 1);
    accept_one();

    finish_run();
  end
endmodule